// File: doc/BRIEF.md
# Fault-Injectable JK Flip-Flop Pair

This block is a small sequential circuit for fault-injection experiments. Each of its input bits is nominally zero and passes through a fault stage before it reaches the flip-flops. When the fault stage's permanent inversion fault is armed, the stage drives the complement of the nominal value. An outside agent arms a fault by pulsing that bit's fail request. After that the fault stays armed until reset, and no repair is possible.

The faulted bits drive a chain of JK flip-flops. Flop 0 takes J from bit 0 and K from bit 1. Flop 1 takes J from bit 1 and K from bit 2. The middle bit therefore feeds both flops. Because of this shared bit, the order in which faults arrive decides whether the output settles or oscillates. The output is the OR of all flop Q values. Each flop also exposes its complement output, and the fault-mode flags are visible so that a test harness can watch them.

The pins carry control and status only, with no streamed data, so no handshake is used. A fail request is sampled on every rising edge, and the block never stalls.

Top module: `jk_fault_pair`

## Requirements
- R1: While `rst` is high at a rising edge, every fault flag, every flop Q and `fault_out` become 0 at that edge.
- R2: A high `fail_req[i]` at a rising edge with `rst` low sets `fault_flag[i]` at that edge, so it reads 1 after the edge.
- R3: Once set, `fault_flag[i]` stays 1 until reset. A further request on an already failed bit has no effect.
- R4: A healthy bit drives its nominal input, and a failed bit (flag 1) drives the inverted nominal input. A fault flag set at an edge first affects the flops at the following edge.
- R5: Each flop follows the JK rule at every rising edge. With J=0 and K=0 it holds. With J=0 and K=1 it clears. With J=1 and K=0 it sets. With J=1 and K=1 it toggles.
- R6: Flop 0 (Q bit 0) uses J = bit 0 and K = bit 1. Flop 1 (Q bit 1) uses J = bit 1 and K = bit 2.
- R7: `fault_out` is the OR of the two flop Q outputs.
- R8: `ff_qn` is always the bitwise complement of `ff_q`.
- R9: Several fail requests on the same edge each set their own flag at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nom_in | input | 3 | Nominal input bits (normally 0) |
| fail_req | input | 3 | Per-bit request to arm the inversion fault |
| fault_flag | output | 3 | Per-bit fault mode, 1 = inverted |
| ff_q | output | 2 | Flop Q outputs, bit i = flop i |
| ff_qn | output | 2 | Complement of `ff_q` |
| fault_out | output | 1 | OR of the flop Q outputs |

## Verification
Two things can happen on the same edge: a fail request arming a flag, and the flops sampling J/K values that still reflect the old flag. The bench provokes this by raising requests in cycles where the flops would change if the fault applied at once. It judges the result against a cycle model in which the new flag reaches J/K only one edge later. Simultaneous requests on bits 0 and 1 make the toggle case collide with the set case. The bench then checks each edge for the alternating Q that this produces, and checks it again when bit 2 fails afterwards in a different order.

// File: rtl/jk_fault_pkg.sv
package jk_fault_pkg;
  typedef enum logic {
    FM_HEALTHY  = 1'b0,
    FM_INVERTED = 1'b1
  } fault_mode_t;

  typedef enum logic [1:0] {
    JK_HOLD   = 2'b00,
    JK_CLEAR  = 2'b01,
    JK_SET    = 2'b10,
    JK_TOGGLE = 2'b11
  } jk_op_t;
endpackage

// File: rtl/jk_fault_stage.sv
module jk_fault_stage
  import jk_fault_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic nom,
  input  logic req,
  output logic failed,
  output logic bit_out
);
  fault_mode_t mode_q;

  always_ff @(posedge clk) begin
    if (rst)                      mode_q <= FM_HEALTHY;
    else if (req)                 mode_q <= FM_INVERTED;
  end

  assign failed  = (mode_q == FM_INVERTED);
  assign bit_out = failed ? ~nom : nom;

  // R2
  req_arms_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> failed);

  // R3
  sticky_fault_chk: assert property (@(posedge clk) disable iff (rst)
    failed |=> failed);
endmodule

// File: rtl/jk_flop.sv
module jk_flop
  import jk_fault_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q,
  output logic qn
);
  jk_op_t op;
  logic   q_r;

  always_comb op = jk_op_t'({j, k});

  always_ff @(posedge clk) begin
    if (rst) q_r <= 1'b0;
    else begin
      unique case (op)
        JK_HOLD:   q_r <= q_r;
        JK_CLEAR:  q_r <= 1'b0;
        JK_SET:    q_r <= 1'b1;
        JK_TOGGLE: q_r <= ~q_r;
      endcase
    end
  end

  assign q  = q_r;
  assign qn = ~q_r;

  // R5
  jk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (j && k) |=> (q != $past(q)));

  // R5
  jk_set_chk: assert property (@(posedge clk) disable iff (rst)
    (j && !k) |=> q);

  // R5
  jk_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!j && k) |=> !q);

  // R5
  jk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!j && !k) |=> $stable(q));
endmodule

// File: rtl/jk_fault_pair.sv
module jk_fault_pair
  import jk_fault_pkg::*;
#(
  parameter int NUM_BITS = 3,
  localparam int NUM_FF  = NUM_BITS - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BITS-1:0] nom_in,
  input  logic [NUM_BITS-1:0] fail_req,
  output logic [NUM_BITS-1:0] fault_flag,
  output logic [NUM_FF-1:0]   ff_q,
  output logic [NUM_FF-1:0]   ff_qn,
  output logic                fault_out
);
  logic [NUM_BITS-1:0] eff_bit;

  for (genvar b = 0; b < NUM_BITS; b++) begin : g_stage
    jk_fault_stage u_stage (
      .clk     (clk),
      .rst     (rst),
      .nom     (nom_in[b]),
      .req     (fail_req[b]),
      .failed  (fault_flag[b]),
      .bit_out (eff_bit[b])
    );
  end

  for (genvar f = 0; f < NUM_FF; f++) begin : g_flop
    jk_flop u_flop (
      .clk (clk),
      .rst (rst),
      .j   (eff_bit[f]),
      .k   (eff_bit[f+1]),
      .q   (ff_q[f]),
      .qn  (ff_qn[f])
    );
  end

  assign fault_out = |ff_q;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (fault_flag == '0 && ff_q == '0 && !fault_out));

  // R8
  qn_compl_chk: assert property (@(posedge clk) disable iff (rst)
    (ff_qn ^ ff_q) == {NUM_FF{1'b1}});
endmodule

// File: tb/test_jk_fault_pair.sv
module test_jk_fault_pair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] nom_in = 3'b000;
  logic [2:0] fail_req = 3'b000;
  logic [2:0] fault_flag;
  logic [1:0] ff_q, ff_qn;
  logic       fault_out;

  int checks = 0;
  int errors = 0;

  logic [2:0] m_flag;
  logic [1:0] m_q;

  always #2 clk = ~clk;

  jk_fault_pair i_jk_fault_pair (
    .clk(clk), .rst(rst), .nom_in(nom_in), .fail_req(fail_req),
    .fault_flag(fault_flag), .ff_q(ff_q), .ff_qn(ff_qn), .fault_out(fault_out)
  );

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(string scen);
    check({scen, " R2/R3/R9 flags"}, {1'b0, fault_flag}, {1'b0, m_flag});
    check({scen, " R4/R5/R6 q"},     {2'b0, ff_q},       {2'b0, m_q});
    check({scen, " R7 out"},         {3'b0, fault_out},  {3'b0, |m_q});
    check({scen, " R8 qn"},          {2'b0, ff_qn},      {2'b0, ~m_q});
  endtask

  task automatic step(string scen, logic [2:0] nom, logic [2:0] req);
    logic [2:0] b;
    nom_in   = nom;
    fail_req = req;
    @(posedge clk);
    b = nom ^ m_flag;
    for (int f = 0; f < 2; f++) begin
      case ({b[f], b[f+1]})
        2'b01: m_q[f] = 1'b0;
        2'b10: m_q[f] = 1'b1;
        2'b11: m_q[f] = ~m_q[f];
        default: ;
      endcase
    end
    m_flag = m_flag | req;
    @(negedge clk);
    compare_all(scen);
  endtask

  task automatic do_reset();
    rst = 1'b1; nom_in = '0; fail_req = '0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_flag = '0; m_q = '0;
    compare_all("R1 reset");
  endtask

  task automatic t_single_bit0();
    do_reset();
    step("R2 arm bit0", 3'b000, 3'b001);   // flag set, flops not yet affected (R4)
    step("R4 bit0 inverted sets ff0", 3'b000, 3'b000);
    step("R5 hold", 3'b000, 3'b000);
    check("R7 out high after bit0 fault", {3'b0, fault_out}, 4'b0001);
  endtask

  task automatic t_sticky();
    do_reset();
    step("R2 arm bit2", 3'b000, 3'b100);
    step("R3 flag held", 3'b000, 3'b000);
    step("R3 repeat request", 3'b000, 3'b100);
    for (int i = 0; i < 3; i++) step("R3 long hold", 3'b000, 3'b000);
  endtask

  task automatic t_healthy_pass();
    do_reset();
    step("R4 healthy J0", 3'b001, 3'b000);
    step("R6 ff1 set via bit1", 3'b010, 3'b000);
    step("R5 toggle ff1", 3'b110, 3'b000);
    step("R5 clear ff0", 3'b010, 3'b000);
    step("R4 failed bit0 with nom1", 3'b001, 3'b001);
    step("R4 inverted nom1 gives 0", 3'b001, 3'b000);
  endtask

  task automatic t_order_12_then_3();
    do_reset();
    step("R9 bits0,1 same edge", 3'b000, 3'b011);
    for (int i = 0; i < 4; i++) step("R5 ff0 oscillates", 3'b000, 3'b000);
    step("R2 bit2 late", 3'b000, 3'b100);
    for (int i = 0; i < 4; i++) step("R6 both toggle", 3'b000, 3'b000);
  endtask

  task automatic t_order_1_3_2();
    do_reset();
    step("R2 bit0 first", 3'b000, 3'b001);
    step("R6 ff0 set", 3'b000, 3'b000);
    step("R2 bit2 second", 3'b000, 3'b100);
    step("R6 ff1 clear", 3'b000, 3'b000);
    step("R2 bit1 last", 3'b000, 3'b010);
    for (int i = 0; i < 4; i++) step("R5 order 1-3-2", 3'b000, 3'b000);
    step("R9 all three again", 3'b000, 3'b111);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_flag = '0; m_q = '0;
    repeat (2) @(negedge clk);
    t_single_bit0();
    t_sticky();
    t_healthy_pass();
    t_order_12_then_3();
    t_order_1_3_2();
    do_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule